// File: doc/BRIEF.md
# Stuck-State Hang Signature Detector

This block decides whether a baseband or a transmit DMA engine has locked up and, if it has, which known failure pattern it matches. It watches one 32-bit baseband observation word and four 32-bit DMA debug words. A request starts a check window. The words are captured once, then re-read a fixed number of times, with a programmable gap between reads. A class of words is treated as frozen only if every re-read equals the captured value. Frozen words are then matched against a small set of fixed signatures, and a one-cycle done pulse returns a hang code.

The baseband class is tested with an ordered list of mask/value patterns. The DMA class is tested against two signatures. The first looks for a particular state in any of ten packed 5-bit per-unit fields together with a completion state. The second checks three packed queue-state fields. A baseband hit takes precedence over the DMA test and suppresses it. Either class can be switched off for each request. The block only reports the code; any recovery is left to whatever consumes it.

Top module: `hang_sig_detector`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `hang_code` is 0 (no hang).
- R2: A class is reported only if each of its words equals its captured value on all `NUM_READS` (default 50) re-reads. A single difference in any word of the class, including on the last re-read, makes that class report no hang. For the DMA class, a difference in any one of the four debug words is enough.
- R3: Baseband patterns are tried in this priority order, each as `(obs & mask) == value`: mask 0x7E000B00 / value 0x1E000000 gives code 1; mask 0x7E000B00 / value 0x52000B00 gives code 2; mask 0x7E000B00 / value 0x18000B00 gives code 3; mask 0x7E7FFFEF / value 0x00702400 gives code 3. Bits outside a mask have no effect.
- R4: DMA signature A (code 4) needs two things. First, one of the ten 5-bit fields must equal 0x06: six fields in `dma_dbg4` at bits [5i+4:5i] for i=0..5, and four in `dma_dbg5` at bits [5j+4:5j] for j=0..3. Second, `dma_dbg6[1:0]` must equal 2'b01.
- R5: DMA signature B (code 5) requires `dma_dbg3[21:18]`=0x9, `dma_dbg3[25:22]`=0x8 and `dma_dbg3[28:26]`=0x4.
- R6: Signature A is tested before signature B. Frozen DMA words that match neither give code 0.
- R7: When a baseband code is reported, the DMA test is not used: the code is the baseband code even if the DMA words match a signature.
- R8: `req_bb_en` and `req_mac_en`, sampled with `req`, enable the two classes. A disabled class never produces its codes. With the baseband class disabled, the DMA result is reported.
- R9: With gap G = `sample_gap` sampled at the request, re-reads happen every G+1 cycles. `done` is a one-cycle pulse exactly NUM_READS*(G+1)+1 cycles after the request edge. `busy` is high from the request until that pulse.
- R10: A `req` asserted while `busy` is high is ignored: it neither restarts the window nor produces an extra `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | Start a check (accepted while idle) |
| req_bb_en | input | 1 | Enable the baseband class for this check |
| req_mac_en | input | 1 | Enable the DMA class for this check |
| sample_gap | input | GAP_W | Idle cycles between re-reads |
| obs_word | input | 32 | Baseband observation word |
| dma_dbg3 | input | 32 | DMA debug word holding the queue-state fields |
| dma_dbg4 | input | 32 | DMA debug word holding six unit-state fields |
| dma_dbg5 | input | 32 | DMA debug word holding four unit-state fields |
| dma_dbg6 | input | 32 | DMA debug word holding the completion state |
| busy | output | 1 | Check window in progress |
| done | output | 1 | One-cycle result strobe |
| hang_code | output | 3 | Result: 0 none, 1..3 baseband, 4..5 DMA; held until the next result |

## Verification
A wrong read counter or gap reload shows up at once as `done` arriving in the wrong cycle. It is visible on the first check of any length, and more clearly with a non-zero gap. A stuck or mis-cleared stability flag leaves no trace until the end of the window. There it shows as a hang reported for words that moved, or as a missed hang for frozen words, so stimulus changes a word early, late, and in each class separately. A wrong snapshot, field slice or priority appears only in `hang_code` at the done pulse. Each signature is therefore driven on its own, together with neighbouring near-misses and overlapping matches.

// File: rtl/hang_det_pkg.sv
package hang_det_pkg;

  localparam int WORD_W   = 32;
  localparam int CODE_W   = 3;
  localparam int BB_SIG_N = 4;

  localparam logic [CODE_W-1:0] HC_NONE      = 3'd0;
  localparam logic [CODE_W-1:0] HC_BB_SPUR   = 3'd1;
  localparam logic [CODE_W-1:0] HC_BB_BURST  = 3'd2;
  localparam logic [CODE_W-1:0] HC_BB_CLEAR  = 3'd3;
  localparam logic [CODE_W-1:0] HC_MAC_CHAIN = 3'd4;
  localparam logic [CODE_W-1:0] HC_MAC_QUEUE = 3'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_EVAL} det_state_e;

  // Baseband pattern list, index 0 has the highest priority.
  function automatic logic [WORD_W-1:0] bb_mask(input int idx);
    case (idx)
      3:       return 32'h7E7F_FFEF;
      default: return 32'h7E00_0B00;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] bb_value(input int idx);
    case (idx)
      0:       return 32'h1E00_0000;
      1:       return 32'h5200_0B00;
      2:       return 32'h1800_0B00;
      default: return 32'h0070_2400;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] bb_code(input int idx);
    case (idx)
      0:       return HC_BB_SPUR;
      1:       return HC_BB_BURST;
      default: return HC_BB_CLEAR;
    endcase
  endfunction

endpackage

// File: rtl/hang_bb_match.sv
module hang_bb_match
  import hang_det_pkg::*;
(
  input  logic [WORD_W-1:0] obs,
  output logic              hit,
  output logic [CODE_W-1:0] code
);

  logic [BB_SIG_N-1:0] sig_hit;

  for (genvar i = 0; i < BB_SIG_N; i++) begin : g_sig
    assign sig_hit[i] = (obs & bb_mask(i)) == bb_value(i);
  end

  // Lowest index wins.
  always_comb begin
    code = HC_NONE;
    for (int i = BB_SIG_N - 1; i >= 0; i--) begin
      if (sig_hit[i]) code = bb_code(i);
    end
  end

  assign hit = |sig_hit;

endmodule

// File: rtl/hang_mac_match.sv
module hang_mac_match #(
  parameter int FIELD_W     = 5,
  parameter int FIELDS_A    = 6,
  parameter int FIELDS_B    = 4,
  parameter int CHAIN_STATE = 6
) (
  input  logic [10:0]                 q_fields,   // queue-state bits [28:18]
  input  logic [FIELDS_A*FIELD_W-1:0] unit_a,
  input  logic [FIELDS_B*FIELD_W-1:0] unit_b,
  input  logic [1:0]                  cmpl,
  output logic                        chain_hit,
  output logic                        queue_hit
);

  localparam int N_FIELDS = FIELDS_A + FIELDS_B;

  logic [N_FIELDS-1:0] field_hit;

  for (genvar i = 0; i < FIELDS_A; i++) begin : g_unit_a
    assign field_hit[i] = unit_a[i*FIELD_W +: FIELD_W] == FIELD_W'(CHAIN_STATE);
  end
  for (genvar j = 0; j < FIELDS_B; j++) begin : g_unit_b
    assign field_hit[FIELDS_A+j] = unit_b[j*FIELD_W +: FIELD_W] == FIELD_W'(CHAIN_STATE);
  end

  assign chain_hit = (|field_hit) && (cmpl == 2'b01);

  // q_fields[3:0]=bits 21:18, [7:4]=bits 25:22, [10:8]=bits 28:26
  assign queue_hit = (q_fields[3:0] == 4'h9) && (q_fields[7:4] == 4'h8) &&
                     (q_fields[10:8] == 3'h4);

endmodule

// File: rtl/hang_sig_detector.sv
module hang_sig_detector
  import hang_det_pkg::*;
#(
  parameter int NUM_READS = 50,
  parameter int GAP_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_bb_en,
  input  logic              req_mac_en,
  input  logic [GAP_W-1:0]  sample_gap,
  input  logic [WORD_W-1:0] obs_word,
  input  logic [WORD_W-1:0] dma_dbg3,
  input  logic [WORD_W-1:0] dma_dbg4,
  input  logic [WORD_W-1:0] dma_dbg5,
  input  logic [WORD_W-1:0] dma_dbg6,
  output logic              busy,
  output logic              done,
  output logic [CODE_W-1:0] hang_code
);

  localparam int CNT_W = $clog2(NUM_READS + 1);

  // Reset synchroniser: asserts at once, releases on the clock.
  logic rst_meta_q, arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      arst_n     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      arst_n     <= rst_meta_q;
    end
  end

  det_state_e        state_q, state_d;
  logic [GAP_W-1:0]  gap_q, gap_cnt_q, gap_cnt_d;
  logic [CNT_W-1:0]  rd_cnt_q, rd_cnt_d;
  logic              bb_ok_q, bb_ok_d, mac_ok_q, mac_ok_d;
  logic              en_bb_q, en_mac_q;
  logic              done_q, done_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic [WORD_W-1:0] s_obs_q, s_d3_q, s_d4_q, s_d5_q, s_d6_q;

  logic              start, read_now;
  logic              bb_same, mac_same;
  logic              bb_hit, chain_hit, queue_hit;
  logic [CODE_W-1:0] bb_code_w;

  assign start    = (state_q == ST_IDLE) && req;
  assign read_now = (state_q == ST_WAIT) && (gap_cnt_q == '0);
  assign bb_same  = obs_word == s_obs_q;
  assign mac_same = (dma_dbg3 == s_d3_q) && (dma_dbg4 == s_d4_q) &&
                    (dma_dbg5 == s_d5_q) && (dma_dbg6 == s_d6_q);

  hang_bb_match u_bb (
    .obs  (s_obs_q),
    .hit  (bb_hit),
    .code (bb_code_w)
  );

  hang_mac_match u_mac (
    .q_fields  (s_d3_q[28:18]),
    .unit_a    (s_d4_q[29:0]),
    .unit_b    (s_d5_q[19:0]),
    .cmpl      (s_d6_q[1:0]),
    .chain_hit (chain_hit),
    .queue_hit (queue_hit)
  );

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    gap_cnt_d = gap_cnt_q;
    rd_cnt_d  = rd_cnt_q;
    bb_ok_d   = bb_ok_q;
    mac_ok_d  = mac_ok_q;
    done_d    = 1'b0;
    code_d    = code_q;
    case (state_q)
      ST_IDLE: begin
        if (req) begin
          state_d   = ST_WAIT;
          gap_cnt_d = sample_gap;
          rd_cnt_d  = '0;
          bb_ok_d   = 1'b1;
          mac_ok_d  = 1'b1;
        end
      end
      ST_WAIT: begin
        if (gap_cnt_q == '0) begin
          bb_ok_d   = bb_ok_q & bb_same;
          mac_ok_d  = mac_ok_q & mac_same;
          rd_cnt_d  = rd_cnt_q + 1'b1;
          gap_cnt_d = gap_q;
          if (rd_cnt_q == CNT_W'(NUM_READS - 1)) state_d = ST_EVAL;
        end else begin
          gap_cnt_d = gap_cnt_q - 1'b1;
        end
      end
      ST_EVAL: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        if (en_bb_q && bb_ok_q && bb_hit)             code_d = bb_code_w;
        else if (en_mac_q && mac_ok_q && chain_hit)   code_d = HC_MAC_CHAIN;
        else if (en_mac_q && mac_ok_q && queue_hit)   code_d = HC_MAC_QUEUE;
        else                                          code_d = HC_NONE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q   <= ST_IDLE;
      gap_cnt_q <= '0;
      rd_cnt_q  <= '0;
      bb_ok_q   <= 1'b0;
      mac_ok_q  <= 1'b0;
      done_q    <= 1'b0;
      code_q    <= HC_NONE;
    end else begin
      state_q   <= state_d;
      gap_cnt_q <= gap_cnt_d;
      rd_cnt_q  <= rd_cnt_d;
      bb_ok_q   <= bb_ok_d;
      mac_ok_q  <= mac_ok_d;
      done_q    <= done_d;
      code_q    <= code_d;
    end
  end

  // Snapshot and request settings, loaded only on an accepted request
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      gap_q    <= '0;
      en_bb_q  <= 1'b0;
      en_mac_q <= 1'b0;
      s_obs_q  <= '0;
      s_d3_q   <= '0;
      s_d4_q   <= '0;
      s_d5_q   <= '0;
      s_d6_q   <= '0;
    end else if (start) begin
      gap_q    <= sample_gap;
      en_bb_q  <= req_bb_en;
      en_mac_q <= req_mac_en;
      s_obs_q  <= obs_word;
      s_d3_q   <= dma_dbg3;
      s_d4_q   <= dma_dbg4;
      s_d5_q   <= dma_dbg5;
      s_d6_q   <= dma_dbg6;
    end
  end

  assign busy      = state_q != ST_IDLE;
  assign done      = done_q;
  assign hang_code = code_q;

endmodule

// File: rtl/hang_sig_detector_chk.sv
module hang_sig_detector_chk #(
  parameter int NUM_READS = 50,
  parameter int GAP_W     = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic [2:0]       hang_code,
  input logic             en_bb,
  input logic             en_mac,
  input logic [GAP_W-1:0] gap
);

  logic [31:0] busy_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len_q <= '0;
    else if (busy) busy_len_q <= busy_len_q + 1'b1;
    else           busy_len_q <= '0;
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_window_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy_len_q == NUM_READS * (32'(gap) + 1) + 1);

  p_code_on_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hang_code) |-> done);

  p_code_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hang_code <= 3'd5);

  p_bb_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hang_code >= 3'd1 && hang_code <= 3'd3) |-> en_bb);

  p_mac_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hang_code >= 3'd4) |-> en_mac);

endmodule

bind hang_sig_detector hang_sig_detector_chk #(
  .NUM_READS (NUM_READS),
  .GAP_W     (GAP_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .hang_code (hang_code),
  .en_bb     (en_bb_q),
  .en_mac    (en_mac_q),
  .gap       (gap_q)
);

// File: tb/test_hang_sig_detector.sv
module test_hang_sig_detector;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_bb_en = 1'b0, req_mac_en = 1'b0;
  logic [15:0] sample_gap = '0;
  logic [31:0] obs = '0, d3 = '0, d4 = '0, d5 = '0, d6 = '0;
  logic        busy, done;
  logic [2:0]  hang_code;
  int          checks = 0, fails = 0;

  always #10 clk = ~clk;   // 50 MHz

  hang_sig_detector i_hang_sig_detector (
    .clk(clk), .rst_n(rst_n), .req(req), .req_bb_en(req_bb_en),
    .req_mac_en(req_mac_en), .sample_gap(sample_gap), .obs_word(obs),
    .dma_dbg3(d3), .dma_dbg4(d4), .dma_dbg5(d5), .dma_dbg6(d6),
    .busy(busy), .done(done), .hang_code(hang_code)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic set_words(input logic [31:0] o, a, b, c, e);
    obs = o; d3 = a; d4 = b; d5 = c; d6 = e;
  endtask

  // Run one check; optionally change a word after n cycles, or pester with req.
  task automatic run(input string tag, input logic bb, input logic mac,
                     input logic [15:0] gap, input int chg_at, input int chg_sel,
                     input logic [31:0] chg_val, input bit pester,
                     input logic [2:0] exp_code);
    int n = 0;
    int extra = 0;
    @(negedge clk);
    req = 1'b1; req_bb_en = bb; req_mac_en = mac; sample_gap = gap;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    chk({tag, " R9 busy"}, busy, 1);
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == chg_at) begin
        case (chg_sel)
          0: obs = chg_val;
          1: d3  = chg_val;
          2: d4  = chg_val;
          3: d5  = chg_val;
          default: d6 = chg_val;
        endcase
      end
      if (pester && n == 5) req = 1'b1;
      if (pester && n == 6) req = 1'b0;
      if (done || n > 100000) break;
    end
    chk({tag, " code"}, hang_code, exp_code);
    chk({tag, " R9 latency"}, n, 50 * (gap + 1) + 1);
    @(negedge clk);
    chk({tag, " R9 pulse"}, done, 0);
    if (pester) begin
      for (int k = 0; k < 60; k++) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk({tag, " R10 no extra done"}, extra, 0);
    end
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 code", hang_code, 0);
  endtask

  task automatic t_bb_sigs;   // R3, noise only in unmasked bits
    set_words(32'h9E00_0001, 0, 0, 0, 0); run("R3 pat0", 1, 1, 0, -1, 0, 0, 0, 3'd1);
    set_words(32'h5200_0B02, 0, 0, 0, 0); run("R3 pat1", 1, 1, 0, -1, 0, 0, 0, 3'd2);
    set_words(32'h9800_0B00, 0, 0, 0, 0); run("R3 pat2", 1, 1, 0, -1, 0, 0, 0, 3'd3);
    set_words(32'h0170_2410, 0, 0, 0, 0); run("R3 pat3", 1, 1, 0, -1, 0, 0, 0, 3'd3);
    set_words(32'h1E00_0100, 0, 0, 0, 0); run("R3 near miss", 1, 1, 0, -1, 0, 0, 0, 3'd0);
  endtask

  task automatic t_mac_chain;   // R4
    set_words(0, 0, 32'h0C00_0000, 0, 1); run("R4 word4 field5", 1, 1, 0, -1, 0, 0, 0, 3'd4);
    set_words(0, 0, 0, 32'h0003_0000, 1); run("R4 word5 field3", 1, 1, 0, -1, 0, 0, 0, 3'd4);
    set_words(0, 0, 32'h0000_0006, 0, 2); run("R4 cmpl wrong", 1, 1, 0, -1, 0, 0, 0, 3'd0);
  endtask

  task automatic t_mac_queue;   // R5
    set_words(0, 32'h1224_0000, 0, 0, 0); run("R5 queue", 1, 1, 0, -1, 0, 0, 0, 3'd5);
    set_words(0, 32'h1424_0000, 0, 0, 0); run("R5 one field off", 1, 1, 0, -1, 0, 0, 0, 3'd0);
  endtask

  task automatic t_mac_order;   // R6
    set_words(0, 32'h1224_0000, 32'h0000_00C0, 0, 1); run("R6 A before B", 1, 1, 0, -1, 0, 0, 0, 3'd4);
    set_words(0, 0, 0, 0, 0); run("R6 none", 1, 1, 0, -1, 0, 0, 0, 3'd0);
  endtask

  task automatic t_bb_first;    // R7
    set_words(32'h1E00_0000, 32'h1224_0000, 32'h0000_0006, 0, 1);
    run("R7 bb wins", 1, 1, 0, -1, 0, 0, 0, 3'd1);
  endtask

  task automatic t_enables;     // R8
    set_words(32'h1E00_0000, 0, 32'h0000_0006, 0, 1);
    run("R8 bb off", 0, 1, 0, -1, 0, 0, 0, 3'd4);
    set_words(0, 32'h1224_0000, 0, 0, 0);
    run("R8 mac off", 1, 0, 0, -1, 0, 0, 0, 3'd0);
    set_words(32'h1E00_0000, 32'h1224_0000, 0, 0, 0);
    run("R8 both off", 0, 0, 0, -1, 0, 0, 0, 3'd0);
  endtask

  task automatic t_unstable;    // R2
    set_words(32'h1E00_0000, 32'h1224_0000, 0, 0, 0);
    run("R2 obs moves", 1, 1, 0, 10, 0, 32'h1E00_0001, 0, 3'd5);
    set_words(32'h0, 32'h1224_0000, 0, 0, 0);
    run("R2 word5 moves", 1, 1, 0, 20, 3, 32'h0000_0001, 0, 3'd0);
    set_words(32'h5200_0B00, 0, 0, 0, 0);
    run("R2 last read", 1, 1, 0, 49, 0, 32'h5200_0B80, 0, 3'd0);
  endtask

  task automatic t_gap;         // R9
    set_words(32'h1E00_0000, 0, 0, 0, 0);
    run("R9 gap3", 1, 1, 3, -1, 0, 0, 0, 3'd1);
  endtask

  task automatic t_busy_req;    // R10
    set_words(0, 32'h1224_0000, 0, 0, 0);
    run("R10 req while busy", 1, 1, 0, -1, 0, 0, 1, 3'd5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_bb_sigs();
    t_mac_chain();
    t_mac_queue();
    t_mac_order();
    t_bb_first();
    t_enables();
    t_unstable();
    t_gap();
    t_busy_req();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule